// File: doc/BRIEF.md
# Page-Buffered Flash Write Controller

This block is the write-side controller of a word-wide, page-programmed non-volatile memory. A host drives a chip-select, write strobe, output strobe, address and data in the style of an asynchronous memory bus. The block samples those pins with its own system clock. Each write cycle loads one word into a page buffer. The first load of a phase opens the page and fixes its page address. The load phase stays open for as long as each new load arrives inside a programmable window. Once the bus has been quiet for a whole window, the block starts a timed programming phase. When that phase ends, it hands the whole page to the memory array in one commit pulse.

While programming is under way, host reads report progress. A read of the most recently loaded word returns that word with the top bit of each byte inverted. On every read, the next-to-top bit of each byte alternates between 0 and 1 from one read to the next. Once the commit has happened, reads return the stored array contents again. Word indices the host never loaded in a phase are committed as all ones. A load that names a different page from the open one is dropped and raises a sticky error flag.

Top module: `flash_page_writer`

## Requirements
- R1: Address bits 6..0 select the word within a 128-word page and bits 15..7 select the page. At a commit, `arr_page` carries the page of the first load in the phase, and word i of `arr_page_data` (bits 16i+15..16i) carries the data loaded with index i.
- R2: Words may be loaded in any index order. A second load to an index that was already loaded in the same phase replaces the earlier data.
- R3: At each commit, every index that was not loaded in that phase is written as 16'hFFFF.
- R4: A load whose page bits differ from the open page is ignored and sets `page_err`. `page_err` then stays at 1 until reset, including across later commits.
- R5: The load phase stays open while each accepted load completes within LOAD_WINDOW clock cycles of the previous one. Once a full window passes with no accepted load, `prog_busy` rises.
- R6: `prog_busy` stays high for exactly PROG_CYCLES clock cycles. It falls on the edge that ends the single-cycle `arr_commit` pulse, and there is exactly one commit per load phase.
- R7: A write cycle is the span in which chip-select and write strobe are both low and the output strobe is high. The address is taken at the first sample of that span and the data at the last sample of it.
- R8: A write strobe pulse while the output strobe is low, or while chip-select is high, loads nothing.
- R9: Write cycles while `prog_busy` is high are ignored. They change no committed data, do not become the polled word, and do not set `page_err`.
- R10: While `prog_busy` is high, a read of the last accepted address returns the loaded data with bits 15 and 7 inverted and bits 13..8 and 5..0 unchanged.
- R11: While `prog_busy` is high, every read returns bits 14 and 6 equal to each other. The first read of a programming phase returns 0 and each later read inverts them. After the commit, reads return the array data unchanged.
- R12: `rdata_oe` is 1 exactly when chip-select and the output strobe are both low, and `rdata` is 0 whenever `rdata_oe` is 0. When not busy, `rdata` equals `arr_rdata`, with `arr_raddr` following `addr`.
- R13: After reset, `prog_busy`, `page_err` and `arr_commit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Host chip-select, active low |
| oe_n | input | 1 | Host output strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| addr | input | 16 | Host word address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid / drive enable |
| prog_busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | Sticky flag for a load aimed at a foreign page |
| arr_commit | output | 1 | One-cycle strobe that writes the page into the array |
| arr_page | output | 9 | Page number being committed |
| arr_page_data | output | 2048 | Whole page image, word i at bits 16i+15..16i |
| arr_raddr | output | 16 | Array read address |
| arr_rdata | input | 16 | Array read data |

## Verification
The bench loads pages in random index order, with repeated indices and only some indices filled. A buffer that is not preset, or one that keeps only the first write to an index, then shows up as stale or wrong words on readback. It changes the address and data partway through a write cycle. A design that latches at the wrong end of the cycle then commits the wrong word at the wrong index. It places loads just inside and well past the inactivity window, and issues loads to a foreign page and loads during programming. Wrong timeout counting starts programming early or late, and wrong gating lets stray words or a spurious error through. During programming it reads the polled word several times and also reads another address, which exposes a missing inversion, a toggle that starts at the wrong phase or never flips, or status bits that survive past the commit.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
   typedef enum logic [1:0] {
      FPW_IDLE = 2'd0,
      FPW_LOAD = 2'd1,
      FPW_PROG = 2'd2
   } fpw_state_e;
endpackage

// File: rtl/fpw_bus_sampler.sv
module fpw_bus_sampler #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_active,
   output logic              wr_start,
   output logic              wr_done,
   output logic              rd_done,
   output logic [ADDR_W-1:0] addr_s,
   output logic [DATA_W-1:0] data_s
);
   localparam int BW = 3 + ADDR_W + DATA_W;
   localparam logic [BW-1:0] RST_VEC = {3'b111, {(BW-3){1'b0}}};

   logic [BW-1:0] stage_q [SYNC_STAGES];
   logic [BW-1:0] pins;
   logic          wr_prev_q, rd_prev_q, rd_active;

   assign pins = {ce_n, we_n, oe_n, addr, wdata};

   // the control strobes and the address/data travel through one chain so they stay aligned
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RST_VEC;
            else        stage_q[0] <= pins;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VEC;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign wr_active = !stage_q[SYNC_STAGES-1][BW-1] && !stage_q[SYNC_STAGES-1][BW-2]
                      && stage_q[SYNC_STAGES-1][BW-3];
   assign rd_active = !stage_q[SYNC_STAGES-1][BW-1] && !stage_q[SYNC_STAGES-1][BW-3];
   assign addr_s    = stage_q[SYNC_STAGES-1][DATA_W +: ADDR_W];
   assign data_s    = stage_q[SYNC_STAGES-1][DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev_q <= 1'b0;
         rd_prev_q <= 1'b0;
      end else begin
         wr_prev_q <= wr_active;
         rd_prev_q <= rd_active;
      end
   end

   assign wr_start = wr_active && !wr_prev_q;
   assign wr_done  = !wr_active && wr_prev_q;
   assign rd_done  = !rd_active && rd_prev_q;
endmodule

// File: rtl/fpw_page_buf.sv
module fpw_page_buf #(
   parameter int DATA_W    = 16,
   parameter int WORD_BITS = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 preset,
   input  logic                                 wr_en,
   input  logic [WORD_BITS-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]                    wr_data,
   output logic [(1<<WORD_BITS)*DATA_W-1:0]     page_flat
);
   localparam int PAGE_WORDS = 1 << WORD_BITS;

   for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (preset)
            word_q <= (wr_idx == WORD_BITS'(w)) ? wr_data : '1;
         else if (wr_en && wr_idx == WORD_BITS'(w))
            word_q <= wr_data;
      end
      assign page_flat[w*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/fpw_status_mux.sv
module fpw_status_mux #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              rd_done,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic [DATA_W-1:0] last_data,
   output logic [DATA_W-1:0] rdata
);
   localparam int NBYTES = DATA_W / 8;

   logic              tog_q;
   logic [DATA_W-1:0] poll_mask, tog_mask, base;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign poll_mask[8*b+7]   = 1'b1;
      assign poll_mask[8*b+6]   = 1'b0;
      assign poll_mask[8*b +: 6] = '0;
      assign tog_mask[8*b+7]    = 1'b0;
      assign tog_mask[8*b+6]    = 1'b1;
      assign tog_mask[8*b +: 6] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog_q <= 1'b0;
      else if (!busy)   tog_q <= 1'b0;
      else if (rd_done) tog_q <= !tog_q;
   end

   always_comb begin
      base = (host_addr == last_addr) ? (last_data ^ poll_mask) : arr_rdata;
      if (!rd_en)
         rdata = '0;
      else if (busy)
         rdata = (base & ~tog_mask) | (tog_q ? tog_mask : '0);
      else
         rdata = arr_rdata;
   end

   AST_TOG_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !tog_q); // R11
   AST_TOG_FLIP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_done) |=> (tog_q != $past(tog_q))); // R11
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int WORD_BITS   = 7,
   parameter int LOAD_WINDOW = 25000,
   parameter int PROG_CYCLES = 625000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ce_n,
   input  logic                                 oe_n,
   input  logic                                 we_n,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic [DATA_W-1:0]                    wdata,
   output logic [DATA_W-1:0]                    rdata,
   output logic                                 rdata_oe,
   output logic                                 prog_busy,
   output logic                                 page_err,
   output logic                                 arr_commit,
   output logic [ADDR_W-WORD_BITS-1:0]          arr_page,
   output logic [(1<<WORD_BITS)*DATA_W-1:0]     arr_page_data,
   output logic [ADDR_W-1:0]                    arr_raddr,
   input  logic [DATA_W-1:0]                    arr_rdata
);
   import fpw_pkg::*;

   localparam int PAGE_W  = ADDR_W - WORD_BITS;
   localparam int CNT_MAX = (LOAD_WINDOW > PROG_CYCLES) ? LOAD_WINDOW : PROG_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (WORD_BITS < 1 || WORD_BITS >= ADDR_W) begin : g_bad_word_bits
      $error("WORD_BITS must lie between 1 and ADDR_W-1");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (LOAD_WINDOW < 2 || PROG_CYCLES < 2) begin : g_bad_timing
      $error("LOAD_WINDOW and PROG_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   fpw_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PAGE_W-1:0] page_q;
   logic              err_q;
   logic [ADDR_W-1:0] addr_cap_q, last_addr_q, addr_s;
   logic [DATA_W-1:0] data_cap_q, last_data_q, data_s;
   logic              wr_active, wr_start, wr_done, rd_done;
   logic              same_page, ld_open, ld_more, ld_bad, ld_accept;
   logic              window_out, prog_end;

   fpw_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .wr_active(wr_active), .wr_start(wr_start),
      .wr_done(wr_done), .rd_done(rd_done), .addr_s(addr_s), .data_s(data_s));

   // address at the opening sample of a write cycle, data refreshed until its closing sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_cap_q <= '0;
         data_cap_q <= '0;
      end else begin
         if (wr_start)  addr_cap_q <= addr_s;
         if (wr_active) data_cap_q <= data_s;
      end
   end

   always_comb begin
      same_page  = addr_cap_q[ADDR_W-1:WORD_BITS] == page_q;
      ld_open    = wr_done && (state_q == FPW_IDLE);
      ld_more    = wr_done && (state_q == FPW_LOAD) && same_page;
      ld_bad     = wr_done && (state_q == FPW_LOAD) && !same_page;
      ld_accept  = ld_open || ld_more;
      window_out = (state_q == FPW_LOAD) && !ld_more && (cnt_q == CNT_W'(LOAD_WINDOW - 1));
      prog_end   = (state_q == FPW_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FPW_IDLE;
         cnt_q   <= '0;
         page_q  <= '0;
      end else begin
         unique case (state_q)
            FPW_IDLE: if (ld_open) begin
               state_q <= FPW_LOAD;
               cnt_q   <= '0;
               page_q  <= addr_cap_q[ADDR_W-1:WORD_BITS];
            end
            FPW_LOAD: begin
               if (ld_more) cnt_q <= '0;
               else if (window_out) begin
                  state_q <= FPW_PROG;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            FPW_PROG: begin
               if (prog_end) begin
                  state_q <= FPW_IDLE;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            end
            default: state_q <= FPW_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q       <= 1'b0;
         last_addr_q <= '0;
         last_data_q <= '0;
      end else begin
         if (ld_bad) err_q <= 1'b1;
         if (ld_accept) begin
            last_addr_q <= addr_cap_q;
            last_data_q <= data_cap_q;
         end
      end
   end

   fpw_page_buf #(.DATA_W(DATA_W), .WORD_BITS(WORD_BITS)) u_buf (
      .clk(clk), .rst_n(rst_n), .preset(ld_open), .wr_en(ld_more),
      .wr_idx(addr_cap_q[WORD_BITS-1:0]), .wr_data(data_cap_q), .page_flat(arr_page_data));

   assign rdata_oe   = !ce_n && !oe_n;
   assign arr_raddr  = addr;
   assign prog_busy  = (state_q == FPW_PROG);
   assign page_err   = err_q;
   assign arr_commit = prog_end;
   assign arr_page   = page_q;

   fpw_status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
      .clk(clk), .rst_n(rst_n), .busy(prog_busy), .rd_done(rd_done), .rd_en(rdata_oe),
      .host_addr(addr), .arr_rdata(arr_rdata), .last_addr(last_addr_q),
      .last_data(last_data_q), .rdata(rdata));

   AST_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_commit |-> prog_busy); // R6
   AST_BUSY_ENDS_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_busy) |-> $past(arr_commit)); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |=> page_err); // R4
   AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |-> !ld_accept); // R9
   AST_PROG_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_busy) |-> $past(cnt_q) == CNT_W'(LOAD_WINDOW - 1)); // R5
   AST_READ_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> rdata == '0); // R12
endmodule

// File: tb/flash_page_writer_bench.sv
module flash_page_writer_bench;
   localparam int W = 40;
   localparam int P = 120;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0] addr = '0, wdata = '0;
   logic [15:0] rdata, arr_raddr, arr_rdata;
   logic rdata_oe, prog_busy, page_err, arr_commit;
   logic [8:0] arr_page;
   logic [2047:0] arr_page_data;

   int checks = 0, fails = 0;
   int cycles = 0;
   int commit_cnt = 0, busy_run = 0, busy_len = 0;
   logic mem_ready = 1'b0;

   logic [15:0] arr_mem [1024];
   logic [15:0] ref_mem [1024];
   logic [15:0] pend [128];
   logic        pend_v [128];
   logic        pend_dup [128];
   logic [15:0] last_a, last_d;
   logic [8:0]  cur_page;

   always #4 clk = !clk;

   flash_page_writer #(.LOAD_WINDOW(W), .PROG_CYCLES(P)) u_flash_page_writer (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .prog_busy(prog_busy),
      .page_err(page_err), .arr_commit(arr_commit), .arr_page(arr_page),
      .arr_page_data(arr_page_data), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata));

   // behavioural array holding pages 0x1A8..0x1AF
   always @(posedge clk) begin
      if (!mem_ready) begin
         for (int i = 0; i < 1024; i++) arr_mem[i] = 16'hFFFF;
         mem_ready = 1'b1;
      end else if (arr_commit) begin
         commit_cnt++;
         if (arr_page[8:3] == 6'h35)
            for (int i = 0; i < 128; i++) arr_mem[{arr_page[2:0], i[6:0]}] = arr_page_data[i*16 +: 16];
      end
   end
   always_comb arr_rdata = (arr_raddr[15:10] == 6'h35) ? arr_mem[arr_raddr[9:0]] : 16'hFFFF;

   always @(negedge clk) begin
      cycles++;
      if (prog_busy) busy_run++;
      else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
      if (cycles > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog R6: actual %0d cycles, expected under 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic [8:0] pg, input logic [6:0] idx);
      return {pg, idx};
   endfunction

   function automatic logic [15:0] status_word(input logic [15:0] base, input logic tog);
      return (base & ~16'h4040) | (tog ? 16'h4040 : 16'h0000);
   endfunction

   task automatic cycle_bus(input logic c, input logic o, input logic [15:0] a, input logic [15:0] d,
                            input logic [15:0] a2, input logic [15:0] d2);
      @(negedge clk); ce_n = c; oe_n = o; we_n = 1'b0; addr = a; wdata = d;
      @(negedge clk); addr = a2; wdata = d2;
      @(negedge clk);
      @(negedge clk); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      cycle_bus(1'b0, 1'b1, a, d, a, d);
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] v);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      @(negedge clk); v = rdata;
      chk("R12 oe during read", {31'd0, rdata_oe}, 32'd1);
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic begin_page(input logic [8:0] pg);
      cur_page = pg;
      for (int i = 0; i < 128; i++) begin pend[i] = 16'hFFFF; pend_v[i] = 1'b0; pend_dup[i] = 1'b0; end
   endtask

   task automatic load(input logic [6:0] idx, input logic [15:0] d);
      wr(mk(cur_page, idx), d);
      if (pend_v[idx]) pend_dup[idx] = 1'b1;
      pend[idx] = d; pend_v[idx] = 1'b1;
      last_a = mk(cur_page, idx); last_d = d;
   endtask

   task automatic wait_busy();
      for (int i = 0; i < 3*W && !prog_busy; i++) @(negedge clk);
      chk("R5 programming started", {31'd0, prog_busy}, 32'd1);
   endtask

   // polling reads during programming, then completion and full readback
   task automatic finish_page();
      logic [15:0] v;
      logic tog;
      int c0;
      c0 = commit_cnt;
      wait_busy();
      tog = 1'b0;
      for (int k = 0; k < 3; k++) begin
         rd(last_a, v);
         chk("R10 polled word", {16'd0, v & ~16'h4040}, {16'd0, (last_d ^ 16'h8080) & ~16'h4040});
         chk("R11 toggle bits", {16'd0, v & 16'h4040}, {16'd0, tog ? 16'h4040 : 16'h0000});
         tog = !tog;
      end
      rd(last_a ^ 16'h0080, v);
      chk("R11 toggle other address", {16'd0, v}, {16'd0, status_word(ref_mem[(last_a ^ 16'h0080) & 16'h03FF], tog)});
      for (int i = 0; i < 4*P && prog_busy; i++) @(negedge clk);
      @(negedge clk);
      chk("R6 busy length", busy_len, P);
      chk("R6 single commit", commit_cnt - c0, 1);
      for (int i = 0; i < 128; i++) ref_mem[{cur_page[2:0], i[6:0]}] = pend[i];
      for (int i = 0; i < 128; i++) begin
         rd(mk(cur_page, i[6:0]), v);
         if (mk(cur_page, i[6:0]) == last_a)
            chk("R11 true data after commit", {16'd0, v}, {16'd0, pend[i]});
         else if (pend_dup[i]) chk("R2 rewritten index", {16'd0, v}, {16'd0, pend[i]});
         else if (pend_v[i])   chk("R1 loaded index", {16'd0, v}, {16'd0, pend[i]});
         else                  chk("R3 unloaded index all ones", {16'd0, v}, 32'h0000FFFF);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      logic [8:0] pg;
      int n;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 1024; i++) ref_mem[i] = 16'hFFFF;
      do_reset();
      chk("R13 busy after reset", {31'd0, prog_busy}, 32'd0);
      chk("R13 err after reset", {31'd0, page_err}, 32'd0);
      chk("R13 commit after reset", {31'd0, arr_commit}, 32'd0);
      chk("R12 rdata idle", {16'd0, rdata}, 32'd0);
      chk("R12 oe idle", {31'd0, rdata_oe}, 32'd0);
      rd(16'hD4A3, v);
      chk("R12 idle read returns array", {16'd0, v}, 32'h0000FFFF);

      // random pages, random index order, some duplicated indices
      for (int r = 0; r < 5; r++) begin
         pg = 9'h1A8 | 9'($urandom % 8);
         begin_page(pg);
         n = 1 + int'($urandom % 24);
         for (int k = 0; k < n; k++) load(7'($urandom % 128), 16'($urandom));
         if (r == 0) begin load(7'd5, 16'h1234); load(7'd5, 16'hBEEF); end
         finish_page();
      end

      // R7: address from the start of the cycle, data from its end
      begin_page(9'h1AA);
      cycle_bus(1'b0, 1'b1, mk(9'h1AA, 7'd10), 16'h1111, mk(9'h1AA, 7'd20), 16'h2222);
      pend[10] = 16'h2222; pend_v[10] = 1'b1; last_a = mk(9'h1AA, 7'd10); last_d = 16'h2222;
      finish_page();
      rd(mk(9'h1AA, 7'd10), v); chk("R7 data at end, address at start", {16'd0, v}, 32'h00002222);
      rd(mk(9'h1AA, 7'd20), v); chk("R7 late address unused", {16'd0, v}, 32'h0000FFFF);

      // R8: inhibited write cycles
      begin_page(9'h1AB);
      load(7'd1, 16'hA5A5);
      cycle_bus(1'b0, 1'b0, mk(9'h1AB, 7'd2), 16'h0F0F, mk(9'h1AB, 7'd2), 16'h0F0F);
      cycle_bus(1'b1, 1'b1, mk(9'h1AB, 7'd3), 16'hF0F0, mk(9'h1AB, 7'd3), 16'hF0F0);
      finish_page();
      rd(mk(9'h1AB, 7'd2), v); chk("R8 output strobe low inhibits", {16'd0, v}, 32'h0000FFFF);
      rd(mk(9'h1AB, 7'd3), v); chk("R8 chip-select high inhibits", {16'd0, v}, 32'h0000FFFF);

      // R5 window and R9 loads while busy
      begin_page(9'h1AC);
      load(7'd40, 16'h4001);
      repeat (W/2) @(negedge clk);
      chk("R5 still loading inside window", {31'd0, prog_busy}, 32'd0);
      load(7'd41, 16'h4002);
      repeat (W-8) @(negedge clk);
      chk("R5 not busy before window ends", {31'd0, prog_busy}, 32'd0);
      repeat (12) @(negedge clk);
      chk("R5 busy after window ends", {31'd0, prog_busy}, 32'd1);
      wr(mk(9'h1AC, 7'd42), 16'h4003);
      chk("R9 no error from busy load", {31'd0, page_err}, 32'd0);
      finish_page();
      rd(mk(9'h1AC, 7'd42), v); chk("R9 busy load ignored", {16'd0, v}, 32'h0000FFFF);
      rd(mk(9'h1AC, 7'd40), v); chk("R5 first load kept", {16'd0, v}, 32'h00004001);

      // R4: foreign page load
      begin_page(9'h1AD);
      load(7'd7, 16'h7777);
      wr(mk(9'h1AE, 7'd8), 16'h8888);
      chk("R4 error raised", {31'd0, page_err}, 32'd1);
      finish_page();
      rd(mk(9'h1AE, 7'd8), v); chk("R4 foreign word dropped", {16'd0, v}, {16'd0, ref_mem[{3'd6, 7'd8}]});
      chk("R4 error sticky after commit", {31'd0, page_err}, 32'd1);
      do_reset();
      chk("R13 error cleared by reset", {31'd0, page_err}, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule